// File: doc/BRIEF.md
# Dual Down-Counter with Selectable Count Sources

This block holds two 16-bit down-counters, timer A and timer B. Each has a reload register and counts down one step per count event. Each timer picks its count events from one of three places. The first is a shared internal prescaler that divides the system clock by a programmable power of two. The second is a rising edge on its own external pin, passed through a synchronizer. The third applies to timer A only: timer B's underflow pulse. Using that third source chains the two timers into one 32-bit down-counter. A timer that decrements from zero loads its reload value and raises a one-clock underflow pulse.

Software reaches the block through a simple write port and a combinational read port, both addressed. It sets the counts, the reloads and one control register that holds the source and the rate for each timer. The underflow pulses go to whatever logic uses the timers, such as an interrupt controller or a waveform generator.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads zero and both underflow outputs are low.
- R2: Register addresses are: 0 count A, 1 reload A, 2 count B, 3 reload B, 4 control. The control register holds rate A in bits [2:0], source A in bits [4:3], rate B in bits [7:5] and source B in bits [9:8]. Its upper bits read zero, and so do addresses 5 to 7.
- R3: Source code 1 selects the internal prescaler. A timer with rate field n then gets one count event every 2^(n+1) clocks, so with reload R its underflow pulses repeat every (R+1)*2^(n+1) clocks.
- R4: Source code 2 selects the timer's pin (pin_a for timer A, pin_b for timer B). Each rising edge of the pin gives exactly one count event, however long the pin then stays high. The count shows the event within four clocks of the edge.
- R5: A count event while the count is zero loads the reload value. It also raises that timer's underflow output for exactly one clock, in the same cycle as the event.
- R6: Source code 3 on timer A makes every timer-B underflow pulse decrement timer A in that same cycle. With rate n, timer A then underflows every (RA+1)*(RB+1)*2^(n+1) clocks.
- R7: Source code 0 stops a timer. Source code 3 on timer B also stops it. A stopped timer keeps its count and gives no underflow.
- R8: A write to a count register takes precedence over a count event in the same cycle. The written value is the value read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | External count input for timer A |
| pin_b | input | 1 | External count input for timer B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| uf_a | output | 1 | Timer A underflow pulse |
| uf_b | output | 1 | Timer B underflow pulse |

## Verification
A wrong prescaler phase or rate decode shows up as an underflow period that differs from (R+1)*2^(n+1). The bench measures that period within one period, across every rate on both timers. A broken reload or a chaining fault shows up either as a wrong count read back in the clock right after a timer-B pulse, or as a timer-A pulse with no timer-B pulse beside it. Counting errors on the pins show up in a readback a few clocks after the edges. A wrongly ordered write against a count event shows up in the very next read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_DIV   = 2'd1,
    SRC_PIN   = 2'd2,
    SRC_CHAIN = 2'd3
  } tmr_src_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT_A = 3'd0;
  localparam logic [ADDR_W-1:0] A_RLD_A = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_B = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_B = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int NCH    = 2,
  parameter int RATE_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCH-1:0][RATE_W-1:0]   rate_i,
  output logic [NCH-1:0]               tick_o
);
  localparam int PSC_W = 1 << RATE_W;

  logic [PSC_W-1:0] psc_q, psc_d;

  always_comb psc_d = psc_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PSC_W-1:0] mask;
    for (genvar b = 0; b < PSC_W; b++) begin : g_bit
      assign mask[b] = (int'(rate_i[c]) >= b);
    end
    assign tick_o[c] = ((psc_q & mask) == mask);
  end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  input  logic [W-1:0] rld_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    uf_o  = 1'b0;
    if (wr_i) begin
      cnt_d = wdata_i;
    end else if (tick_i) begin
      if (at_zero) begin
        cnt_d = rld_i;
        uf_o  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int RATE_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              uf_a,
  output logic              uf_b
);
  localparam int FLD_W  = RATE_W + 2;
  localparam int CTRL_W = 2 * FLD_W;

  logic [CNT_W-1:0]  rld_a, rld_b, rld_a_d, rld_b_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_a, cnt_b;
  logic              wr_cnt_a, wr_cnt_b;
  tmr_src_e          src_a, src_b;
  logic [1:0][RATE_W-1:0] rate;
  logic [1:0]        div_tick, pin_rise, pins;
  logic              tick_a, tick_b;

  assign wr_cnt_a = wr_en && (wr_addr == A_CNT_A);
  assign wr_cnt_b = wr_en && (wr_addr == A_CNT_B);

  always_comb begin
    rld_a_d = rld_a;
    rld_b_d = rld_b;
    ctrl_d  = ctrl_q;
    if (wr_en) begin
      unique case (wr_addr)
        A_RLD_A: rld_a_d = wr_data;
        A_RLD_B: rld_b_d = wr_data;
        A_CTRL:  ctrl_d  = wr_data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_a  <= '0;
      rld_b  <= '0;
      ctrl_q <= '0;
    end else begin
      rld_a  <= rld_a_d;
      rld_b  <= rld_b_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign rate[0] = ctrl_q[RATE_W-1:0];
  assign src_a   = tmr_src_e'(ctrl_q[FLD_W-1:RATE_W]);
  assign rate[1] = ctrl_q[FLD_W+RATE_W-1:FLD_W];
  assign src_b   = tmr_src_e'(ctrl_q[CTRL_W-1:FLD_W+RATE_W]);

  tmr_prescale #(.NCH(2), .RATE_W(RATE_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .rate_i(rate), .tick_o(div_tick)
  );

  assign pins = {pin_b, pin_a};
  for (genvar i = 0; i < 2; i++) begin : g_pin
    tmr_edge #(.STAGES(SYNC_N)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_i(pins[i]), .rise_o(pin_rise[i])
    );
  end

  always_comb begin
    unique case (src_b)
      SRC_DIV: tick_b = div_tick[1];
      SRC_PIN: tick_b = pin_rise[1];
      default: tick_b = 1'b0;
    endcase
  end

  tmr_count #(.W(CNT_W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_cnt_b), .wdata_i(wr_data),
    .tick_i(tick_b), .rld_i(rld_b), .cnt_o(cnt_b), .uf_o(uf_b)
  );

  always_comb begin
    unique case (src_a)
      SRC_DIV:   tick_a = div_tick[0];
      SRC_PIN:   tick_a = pin_rise[0];
      SRC_CHAIN: tick_a = uf_b;
      default:   tick_a = 1'b0;
    endcase
  end

  tmr_count #(.W(CNT_W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_cnt_a), .wdata_i(wr_data),
    .tick_i(tick_a), .rld_i(rld_a), .cnt_o(cnt_a), .uf_o(uf_a)
  );

  always_comb begin
    unique case (rd_addr)
      A_CNT_A: rd_data = cnt_a;
      A_RLD_A: rd_data = rld_a;
      A_CNT_B: rd_data = cnt_b;
      A_RLD_B: rd_data = rld_b;
      A_CTRL:  rd_data = CNT_W'(ctrl_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b,
  input logic [CNT_W-1:0]  rld_a,
  input logic [CNT_W-1:0]  rld_b,
  input tmr_src_e          src_a,
  input tmr_src_e          src_b,
  input logic              uf_a,
  input logic              uf_b
);
  logic wa, wb;
  assign wa = wr_en && (wr_addr == A_CNT_A);
  assign wb = wr_en && (wr_addr == A_CNT_B);

  a_r5_b_reload: assert property (@(posedge clk) disable iff (!rst_n)
    uf_b |=> cnt_b == $past(rld_b));
  a_r5_a_reload: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a |=> cnt_a == $past(rld_a));
  a_r5_b_single: assert property (@(posedge clk) disable iff (!rst_n)
    uf_b |=> !uf_b);
  a_r5_a_single: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a |=> !uf_a);
  a_r6_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == SRC_CHAIN && uf_b && !wa) |=>
      cnt_a == (($past(cnt_a) == '0) ? $past(rld_a) : $past(cnt_a) - 1'b1));
  a_r6_chain_only: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == SRC_CHAIN && uf_a) |-> uf_b);
  a_r7_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == SRC_OFF && !wa) |=> $stable(cnt_a));
  a_r7_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_b == SRC_OFF || src_b == SRC_CHAIN) && !wb) |=> $stable(cnt_b));
  a_r7_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b == SRC_OFF || src_b == SRC_CHAIN) |-> !uf_b);
  a_r3_b_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wb |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) - 1'b1 ||
             cnt_b == $past(rld_b)));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wb |=> cnt_b == $past(wr_data));
endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cnt_a(cnt_a), .cnt_b(cnt_b), .rld_a(rld_a),
  .rld_b(rld_b), .src_a(src_a), .src_b(src_b), .uf_a(uf_a), .uf_b(uf_b)
);

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        uf_a, uf_b;

  int checks = 0;
  int errors = 0;
  int ufa_cnt = 0;
  int lone_ufa = 0;

  always #2.5 clk = ~clk;

  tmr_pair u_dut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .uf_a(uf_a), .uf_b(uf_b)
  );

  always @(negedge clk) begin
    if (uf_a) ufa_cnt++;
    if (uf_a && !uf_b) lone_ufa++;
  end

  function automatic logic [15:0] ctl(int ra, int sa, int rb, int sb);
    return 16'((sb << 8) | (rb << 5) | (sa << 3) | ra);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic measure(bit use_b, output int per, output int wide);
    int t;
    t = 0; wide = 0;
    while (!(use_b ? uf_b : uf_a) && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    if (use_b ? uf_b : uf_a) wide = 1;
    t = 1;
    while (!(use_b ? uf_b : uf_a) && t < 20000) begin @(negedge clk); t++; end
    per = t;
  endtask

  task automatic pulse(bit use_b, int hi);
    @(negedge clk);
    if (use_b) pin_b = 1'b1; else pin_a = 1'b1;
    repeat (hi) @(negedge clk);
    if (use_b) pin_b = 1'b0; else pin_a = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, per, wide, base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1", v, 0); end
    chk("R1 uf_a", int'(uf_a), 0);
    chk("R1 uf_b", int'(uf_b), 0);

    // R2 register map and readback
    wr(3'd4, ctl(5, 0, 6, 0));
    wr(3'd0, 16'h1234); wr(3'd1, 16'hABCD);
    wr(3'd2, 16'h0F0F); wr(3'd3, 16'hFFFF);
    rd(3'd0, v); chk("R2 cnt_a", v, 16'h1234);
    rd(3'd1, v); chk("R2 rld_a", v, 16'hABCD);
    rd(3'd2, v); chk("R2 cnt_b", v, 16'h0F0F);
    rd(3'd3, v); chk("R2 rld_b", v, 16'hFFFF);
    rd(3'd4, v); chk("R2 ctrl", v, 16'h00C5);
    rd(3'd6, v); chk("R2 unused", v, 0);
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); chk("R2 ctrl upper", v, 16'h03FF);

    // R7 timer A chained with B stopped (code 3): nothing moves
    repeat (300) @(negedge clk);
    rd(3'd0, v); chk("R7 a hold", v, 16'h1234);
    rd(3'd2, v); chk("R7 b code3 hold", v, 16'h0F0F);
    pulse(1'b1, 2);
    rd(3'd2, v); chk("R7 b code3 pin", v, 16'h0F0F);
    wr(3'd4, 16'h0000);
    pulse(1'b0, 2);
    rd(3'd0, v); chk("R7 a off pin", v, 16'h1234);

    // R3 / R5 internal prescaler sweep, timer B reload 3
    for (int n = 0; n < 8; n++) begin
      wr(3'd4, 16'h0000);
      wr(3'd3, 16'd3); wr(3'd2, 16'd3);
      wr(3'd4, ctl(0, 0, n, 1));
      measure(1'b1, per, wide);
      chk("R3 period b", per, 4 * (1 << (n + 1)));
      chk("R5 width b", wide, 0);
    end
    // timer A reload 2
    for (int n = 0; n < 8; n++) begin
      wr(3'd4, 16'h0000);
      wr(3'd1, 16'd2); wr(3'd0, 16'd2);
      wr(3'd4, ctl(n, 1, 0, 0));
      measure(1'b0, per, wide);
      chk("R3 period a", per, 3 * (1 << (n + 1)));
      chk("R5 width a", wide, 0);
    end

    // R4 / R5 external pin counting on A
    wr(3'd4, 16'h0000);
    wr(3'd1, 16'd7); wr(3'd0, 16'd10);
    wr(3'd4, ctl(0, 2, 0, 0));
    pulse(1'b0, 1); pulse(1'b0, 3); pulse(1'b0, 10); pulse(1'b0, 2);
    rd(3'd0, v); chk("R4 four edges", v, 6);
    base = ufa_cnt;
    for (int k = 0; k < 6; k++) pulse(1'b0, 1);
    rd(3'd0, v); chk("R4 to zero", v, 0);
    chk("R5 no uf before wrap", ufa_cnt - base, 0);
    pulse(1'b0, 1);
    rd(3'd0, v); chk("R5 reload on wrap", v, 7);
    chk("R5 one pulse", ufa_cnt - base, 1);
    // pin B
    wr(3'd2, 16'd5);
    wr(3'd4, ctl(0, 0, 0, 2));
    pulse(1'b1, 20); pulse(1'b1, 1);
    rd(3'd2, v); chk("R4 pin b", v, 3);

    // R6 cascade: B rate0 reload1, A reload2 -> A period 2*3*2 = 12
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'd1); wr(3'd2, 16'd1);
    wr(3'd1, 16'd2); wr(3'd0, 16'd2);
    wr(3'd4, ctl(0, 3, 0, 1));
    lone_ufa = 0;
    measure(1'b0, per, wide);
    chk("R6 chain period", per, 12);
    rd_addr = 3'd0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (uf_b) begin
        v = int'(rd_data);
        @(negedge clk);
        chk("R6 same-cycle step", int'(rd_data), (v == 0) ? 2 : v - 1);
      end
    end
    chk("R6 no lone A pulse", lone_ufa, 0);
    // 32-bit: B rate1 reload4, A reload3 -> 5*4*4 = 80
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'd4); wr(3'd2, 16'd4);
    wr(3'd1, 16'd3); wr(3'd0, 16'd3);
    wr(3'd4, ctl(0, 3, 1, 1));
    measure(1'b0, per, wide);
    chk("R6 chain 32-bit period", per, 80);

    // R8 write beats a same-cycle count event (B ticks every 2 clocks)
    wr(3'd4, ctl(0, 0, 0, 1));
    wr(3'd3, 16'd5);
    for (int off = 0; off < 2; off++) begin
      @(negedge clk);
      repeat (off) @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd9;
      repeat (3) @(negedge clk);
      wr_en = 1'b0;
      rd(3'd2, v); chk("R8 write wins", v, 9);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule